// File: doc/BRIEF.md
# Grouped Interrupt Router with Fast-Interrupt Select

This block gathers the chip's peripheral interrupt sources into one 16-bit pending word. Each implemented bit latches on the rising edge of its source. A software-visible enable word masks the pending word. A clear strobe removes pending bits using write-one-to-clear. The enabled pending bits are merged onto eight prioritised interrupt request lines, numbered 0 to 7, and each line has a fixed vector address from 0xFFF8 upwards. Lines 0, 1 and 4 are not taken from the pending word. They follow the picture-unit request, the sound-unit request and the sound beat request directly.

A 3-bit group selector takes one whole device group off its normal line and moves it onto a single fast-interrupt output, whose vector is 0xFFF6. Code 7 leaves the fast line unused. The block also presents the vector address of the winning request. The fast line beats every request line. Among the request lines, the lowest-numbered active line wins. All outputs are registered.

Top module: `irq_fiq_router`

## Requirements
- R1: Reset clears the enable word, the pending word, all eight request lines and the fast line, and drives the vector output to 0x0000.
- R2: A rising edge on an implemented source bit sets its pending bit on the same clock edge, whether or not the bit is enabled. The bit stays set until it is cleared. A source held high after a clear does not set the bit again.
- R3: A clear strobe removes every pending bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: If a rising edge and a clear for the same bit arrive on the same edge, the bit ends up set.
- R5: A write to the enable word loads it. Bits 15, 14 and 2 are not implemented: they read 0 in both the enable word and the pending word.
- R6: Bit layout and line mapping, where a bit counts only when it is both pending and enabled:
  - Line 2 takes timer A (bit 11) and timer B (bit 10).
  - Line 3 takes the UART (bit 8) and the ADC (bit 13).
  - Line 5 takes external 1 (bit 9) and external 2 (bit 12).
  - Line 6 takes the 4096/2048/1024 Hz ticks (bits 6, 5, 4).
  - Line 7 takes key change (bit 7), the 4 Hz tick (bit 3), timebase 1 (bit 1) and timebase 2 (bit 0).
- R7: Line 0 follows the picture request, line 1 follows the sound request and line 4 follows the beat request. These three do not pass through the pending word.
- R8: The fast-line select codes are 0 picture, 1 sound, 2 timer A, 3 timer B, 4 UART, 5 both externals, 6 ADC and 7 none. The fast line is the OR of the selected group. That group is removed from its usual request line. With code 7 the fast line stays low.
- R9: The vector output is chosen as follows:
  - 0xFFF6 when the fast line is high.
  - Otherwise 0xFFF8 plus the number of the lowest-numbered active request line.
  - Otherwise 0x0000.
- R10: The request lines, the fast line and the vector are registered from the values present at a clock edge. A direct request therefore shows one edge after it is sampled, and a pending-word event shows one edge after its bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 16 | Level inputs of the edge-latched sources |
| ppu_req | input | 1 | Picture-unit request, drives line 0 |
| spu_req | input | 1 | Sound-unit request, drives line 1 |
| beat_req | input | 1 | Sound beat/envelope request, drives line 4 |
| en_wr | input | 1 | Enable word write strobe |
| en_wdata | input | 16 | Enable word write data |
| clr_wr | input | 1 | Clear strobe |
| clr_wdata | input | 16 | Clear mask, write one to clear |
| fiq_sel | input | 3 | Fast-line group select |
| enable_o | output | 16 | Current enable word |
| status_o | output | 16 | Current pending word |
| irq_o | output | 8 | Request lines 0 to 7 |
| fiq_o | output | 1 | Fast interrupt line |
| vec_o | output | 16 | Vector of the winning request |

## Verification
The assertions assume that each source is a level sampled synchronously by the block. They also assume that a rising edge is one low sample followed by a high sample, with nothing happening between edges. The stimulus changes every input only at the falling clock edge and holds it for a full cycle, so no edge is ever hidden. The random phase draws arbitrary values for the select code, the clear masks and the enable words, including the unimplemented bits. This checks that codes and bits outside the layout have no effect.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int SRC_W  = 16;
    localparam int LINE_N = 8;
    localparam int SEL_W  = 3;
    localparam int VEC_W  = 16;

    localparam logic [SRC_W-1:0] IMPL_MASK = 16'h3FFB;

    localparam int B_TB2  = 0;
    localparam int B_TB1  = 1;
    localparam int B_T4HZ = 3;
    localparam int B_T1K  = 4;
    localparam int B_T2K  = 5;
    localparam int B_T4K  = 6;
    localparam int B_KEY  = 7;
    localparam int B_UART = 8;
    localparam int B_EXT1 = 9;
    localparam int B_TMRB = 10;
    localparam int B_TMRA = 11;
    localparam int B_EXT2 = 12;
    localparam int B_ADC  = 13;

    localparam logic [SEL_W-1:0] SEL_PPU  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SPU  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_TMRA = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TMRB = 3'd3;
    localparam logic [SEL_W-1:0] SEL_UART = 3'd4;
    localparam logic [SEL_W-1:0] SEL_EXT  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_ADC  = 3'd6;

    localparam logic [VEC_W-1:0] VEC_LINE0 = 16'hFFF8;
    localparam logic [VEC_W-1:0] VEC_FAST  = 16'hFFF6;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_in,
    input  logic             en_wr,
    input  logic [SRC_W-1:0] en_wdata,
    input  logic             clr_wr,
    input  logic [SRC_W-1:0] clr_wdata,
    output logic [SRC_W-1:0] enable_q,
    output logic [SRC_W-1:0] status_q,
    output logic [SRC_W-1:0] active
);
    logic [SRC_W-1:0] src_d;
    logic [SRC_W-1:0] rise;
    logic [SRC_W-1:0] wipe;

    assign rise   = src_in & ~src_d & IMPL_MASK;
    assign wipe   = clr_wr ? clr_wdata : '0;
    assign active = status_q & enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_d    <= '0;
            status_q <= '0;
            enable_q <= '0;
        end else begin
            src_d    <= src_in;
            // a fresh edge outranks a clear on the same bit
            status_q <= (status_q & ~wipe) | rise;
            if (en_wr) begin
                enable_q <= en_wdata & IMPL_MASK;
            end
        end
    end
endmodule

// File: rtl/irq_group_map.sv
module irq_group_map
    import irq_route_pkg::*;
(
    input  logic [SRC_W-1:0]  active,
    input  logic              ppu_req,
    input  logic              spu_req,
    input  logic              beat_req,
    input  logic [SEL_W-1:0]  fiq_sel,
    output logic [LINE_N-1:0] lines,
    output logic              fast
);
    logic g_tmra, g_tmrb, g_uart, g_adc, g_ext;
    logic unused_bits;

    assign g_tmra = active[B_TMRA];
    assign g_tmrb = active[B_TMRB];
    assign g_uart = active[B_UART];
    assign g_adc  = active[B_ADC];
    assign g_ext  = active[B_EXT1] | active[B_EXT2];
    assign unused_bits = ^{active[15:14], active[2]};

    always_comb begin
        lines    = '0;
        lines[0] = ppu_req & (fiq_sel != SEL_PPU);
        lines[1] = spu_req & (fiq_sel != SEL_SPU);
        lines[2] = (g_tmra & (fiq_sel != SEL_TMRA)) |
                   (g_tmrb & (fiq_sel != SEL_TMRB));
        lines[3] = (g_uart & (fiq_sel != SEL_UART)) |
                   (g_adc  & (fiq_sel != SEL_ADC));
        lines[4] = beat_req;
        lines[5] = g_ext & (fiq_sel != SEL_EXT);
        lines[6] = active[B_T4K] | active[B_T2K] | active[B_T1K];
        lines[7] = active[B_KEY] | active[B_T4HZ] | active[B_TB1] | active[B_TB2];

        unique case (fiq_sel)
            SEL_PPU:  fast = ppu_req;
            SEL_SPU:  fast = spu_req;
            SEL_TMRA: fast = g_tmra;
            SEL_TMRB: fast = g_tmrb;
            SEL_UART: fast = g_uart;
            SEL_EXT:  fast = g_ext;
            SEL_ADC:  fast = g_adc;
            default:  fast = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick
    import irq_route_pkg::*;
(
    input  logic [LINE_N-1:0] lines,
    input  logic              fast,
    output logic [VEC_W-1:0]  vec
);
    always_comb begin
        vec = '0;
        for (int i = LINE_N - 1; i >= 0; i--) begin
            if (lines[i]) begin
                vec = VEC_LINE0 + VEC_W'(i);
            end
        end
        if (fast) begin
            vec = VEC_FAST;
        end
    end
endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_in,
    input  logic              ppu_req,
    input  logic              spu_req,
    input  logic              beat_req,
    input  logic              en_wr,
    input  logic [SRC_W-1:0]  en_wdata,
    input  logic              clr_wr,
    input  logic [SRC_W-1:0]  clr_wdata,
    input  logic [SEL_W-1:0]  fiq_sel,
    output logic [SRC_W-1:0]  enable_o,
    output logic [SRC_W-1:0]  status_o,
    output logic [LINE_N-1:0] irq_o,
    output logic              fiq_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic [SRC_W-1:0]  active;
    logic [LINE_N-1:0] lines_c;
    logic              fast_c;
    logic [VEC_W-1:0]  vec_c;

    irq_pend_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .clr_wr    (clr_wr),
        .clr_wdata (clr_wdata),
        .enable_q  (enable_o),
        .status_q  (status_o),
        .active    (active)
    );

    irq_group_map u_map (
        .active   (active),
        .ppu_req  (ppu_req),
        .spu_req  (spu_req),
        .beat_req (beat_req),
        .fiq_sel  (fiq_sel),
        .lines    (lines_c),
        .fast     (fast_c)
    );

    irq_vec_pick u_pick (
        .lines (lines_c),
        .fast  (fast_c),
        .vec   (vec_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= '0;
            fiq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= lines_c;
            fiq_o <= fast_c;
            vec_o <= vec_c;
        end
    end
endmodule

// File: rtl/irq_fiq_router_chk.sv
module irq_fiq_router_chk
    import irq_route_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src_in,
    input logic              clr_wr,
    input logic [SRC_W-1:0]  clr_wdata,
    input logic [SEL_W-1:0]  fiq_sel,
    input logic [SRC_W-1:0]  enable_o,
    input logic [SRC_W-1:0]  status_o,
    input logic [LINE_N-1:0] irq_o,
    input logic              fiq_o,
    input logic [VEC_W-1:0]  vec_o
);
    logic [SRC_W-1:0] seen_d;
    logic [SRC_W-1:0] edge_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_d <= '0;
        else        seen_d <= src_in;
    end
    assign edge_c = src_in & ~seen_d & IMPL_MASK;

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_c != '0) |=> ((status_o & $past(edge_c)) == $past(edge_c)));

    p_clear_wipes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status_o & $past(clr_wdata & ~edge_c)) == '0));

    p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_o | enable_o) & ~IMPL_MASK) == '0));

    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o == '0) |=> ((irq_o & 8'hEC) == '0));

    p_fast_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_sel == 3'd7) |=> !fiq_o);

    p_fast_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (vec_o == 16'hFFF6));

    p_idle_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o == '0) && !fiq_o) |-> (vec_o == '0));
endmodule

bind irq_fiq_router irq_fiq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .clr_wr    (clr_wr),
    .clr_wdata (clr_wdata),
    .fiq_sel   (fiq_sel),
    .enable_o  (enable_o),
    .status_o  (status_o),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .vec_o     (vec_o)
);

// File: tb/irq_fiq_router_bench.sv
`timescale 1ns/100ps
module irq_fiq_router_bench;
    localparam logic [15:0] MASK = 16'h3FFB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic        ppu_req = 1'b0, spu_req = 1'b0, beat_req = 1'b0;
    logic        en_wr = 1'b0, clr_wr = 1'b0;
    logic [15:0] en_wdata = '0, clr_wdata = '0;
    logic [2:0]  fiq_sel = 3'd7;
    logic [15:0] enable_o, status_o, vec_o;
    logic [7:0]  irq_o;
    logic        fiq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_en = '0, m_stat = '0, m_prev = '0;
    logic [7:0]  e_irq = '0;
    logic        e_fiq = 1'b0;
    logic [15:0] e_vec = '0;

    always #2.5 clk = ~clk;

    irq_fiq_router u_irq_fiq_router (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .ppu_req(ppu_req),
        .spu_req(spu_req), .beat_req(beat_req), .en_wr(en_wr),
        .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .fiq_sel(fiq_sel), .enable_o(enable_o), .status_o(status_o),
        .irq_o(irq_o), .fiq_o(fiq_o), .vec_o(vec_o)
    );

    function automatic logic [7:0] ref_lines(logic [15:0] a, logic [2:0] s,
                                             logic p, logic q, logic b);
        logic [7:0] l;
        l[0] = p && s != 0;
        l[1] = q && s != 1;
        l[2] = (a[11] && s != 2) || (a[10] && s != 3);
        l[3] = (a[8] && s != 4) || (a[13] && s != 6);
        l[4] = b;
        l[5] = (a[9] || a[12]) && s != 5;
        l[6] = a[4] || a[5] || a[6];
        l[7] = a[0] || a[1] || a[3] || a[7];
        return l;
    endfunction

    function automatic logic ref_fast(logic [15:0] a, logic [2:0] s, logic p, logic q);
        case (s)
            3'd0: return p;
            3'd1: return q;
            3'd2: return a[11];
            3'd3: return a[10];
            3'd4: return a[8];
            3'd5: return a[9] || a[12];
            3'd6: return a[13];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ref_vec(logic [7:0] l, logic f);
        if (f) return 16'hFFF6;
        for (int i = 0; i < 8; i++) if (l[i]) return 16'hFFF8 + 16'(i);
        return 16'h0000;
    endfunction

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // inputs are already set at a falling edge; advance one cycle and compare
    task automatic step(string tag);
        logic [15:0] rise;
        rise  = src_in & ~m_prev & MASK;
        e_irq = ref_lines(m_stat & m_en, fiq_sel, ppu_req, spu_req, beat_req);
        e_fiq = ref_fast(m_stat & m_en, fiq_sel, ppu_req, spu_req);
        e_vec = ref_vec(e_irq, e_fiq);
        m_stat = ((m_stat & ~(clr_wr ? clr_wdata : 16'h0)) | rise) & MASK;
        if (en_wr) m_en = en_wdata & MASK;
        m_prev = src_in;
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "status", status_o, m_stat);
        cmp(tag, "enable", enable_o, m_en);
        cmp(tag, "irq", {8'h0, irq_o}, {8'h0, e_irq});
        cmp(tag, "fiq", {15'h0, fiq_o}, {15'h0, e_fiq});
        cmp(tag, "vec", vec_o, e_vec);
        en_wr  = 1'b0;
        clr_wr = 1'b0;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "status", status_o, 16'h0);
        cmp("R1", "enable", enable_o, 16'h0);
        cmp("R1", "irq", {8'h0, irq_o}, 16'h0);
        cmp("R1", "vec", vec_o, 16'h0);
        rst_n = 1'b1;
        step("R1");

        // R2: edge latches with enables off, level hold does not re-set
        src_in = 16'h0008; step("R2");
        step("R2");
        clr_wr = 1'b1; clr_wdata = 16'h0001; step("R3");
        clr_wr = 1'b1; clr_wdata = 16'h0008; step("R3");
        step("R2");
        // R4: edge and clear together
        src_in = 16'h0018; clr_wr = 1'b1; clr_wdata = 16'h0010; step("R4");
        // R5: unimplemented bits
        en_wr = 1'b1; en_wdata = 16'hFFFF; src_in = 16'h0000; step("R5");
        src_in = 16'hFFFF; step("R5");
        step("R10");
        clr_wr = 1'b1; clr_wdata = 16'hFFFF; src_in = 16'h0; step("R3");
        step("R10");
        // R6: each group alone
        for (int b = 0; b < 16; b++) begin
            src_in = 16'h0001 << b; step("R6");
            step("R6");
            clr_wr = 1'b1; clr_wdata = 16'hFFFF; src_in = 16'h0; step("R6");
            step("R6");
        end
        // R7: direct requests
        ppu_req = 1'b1; step("R7");
        ppu_req = 1'b0; spu_req = 1'b1; step("R7");
        spu_req = 1'b0; beat_req = 1'b1; step("R7");
        beat_req = 1'b0; step("R7");
        // R8/R9: every select with everything raised
        src_in = 16'hFFFF; ppu_req = 1'b1; spu_req = 1'b1; beat_req = 1'b1; step("R8");
        for (int s = 0; s < 8; s++) begin
            fiq_sel = 3'(s); step("R8");
            step("R9");
        end
        ppu_req = 1'b0; spu_req = 1'b0; fiq_sel = 3'd7; step("R9");
        clr_wr = 1'b1; clr_wdata = 16'h3F7F; step("R9");
        step("R9");

        // random phase
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3) == 0) src_in = 16'($urandom);
            ppu_req  = 1'($urandom);
            spu_req  = 1'($urandom);
            beat_req = 1'($urandom);
            fiq_sel  = 3'($urandom);
            if ($urandom_range(5) == 0) begin en_wr = 1'b1; en_wdata = 16'($urandom); end
            if ($urandom_range(3) == 0) begin clr_wr = 1'b1; clr_wdata = 16'($urandom); end
            step("R6");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule